// File: doc/BRIEF.md
# Single-Word Four-Phase Handshake Buffer

This block sits between an upstream sender and a downstream receiver and holds at most one data word. Each side speaks its own fully interlocked four-phase request/acknowledge protocol. The sender places a word on its bus and raises a request. The buffer accepts the word only while it is empty. It answers with an acknowledge and keeps it high until the sender withdraws the request.

When a word is held and the input transaction has been closed, the buffer raises its output request with the word on the output bus. The receiver acknowledges the word. The buffer then withdraws its request, and the receiver completes the cycle by lowering its acknowledge. Captures and deliveries therefore alternate strictly. A word is never lost and never delivered twice. Reset is synchronous and active high.

Top module: `wordbuf_4ph`

## Requirements
- R1: While `rst` is high at a clock edge, `src_ack` and `dst_req` are low after that edge, and the buffer is empty, so that the first sender request after reset is accepted.
- R2: When `src_req` is high, `src_ack` is low and the buffer is empty, `src_ack` is high after the next clock edge and the word on `src_data` at that edge is captured.
- R3: `src_ack` rises only in response to a high `src_req`. It stays high while `src_req` stays high, and it falls at the first edge that sees `src_req` low.
- R4: While the buffer is full, a sender request gets no acknowledge and does not change the held word. It is accepted only after the held word has been taken by the receiver.
- R5: `dst_req` rises only when a word is held and `src_ack` was low at the previous edge. It therefore rises no earlier than one cycle after the input acknowledge drops.
- R6: `dst_req` never rises while `dst_ack` is high. Once raised, it stays high until `dst_ack` is seen high, and it falls at that edge.
- R7: The value on `dst_data` when `dst_ack` rises equals the word captured at the most recent rise of `src_ack`.
- R8: Between any two rising edges of `src_ack` there is a rising edge of `dst_ack` (no overflow).
- R9: Between any two rising edges of `dst_ack` there is a rising edge of `src_ack` (no underflow).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 1 | Sender request |
| src_data | input | DATA_W (32) | Word offered by the sender |
| src_ack | output | 1 | Acknowledge to the sender |
| dst_req | output | 1 | Request to the receiver |
| dst_data | output | DATA_W (32) | Held word; meaningful only while `dst_req` is high |
| dst_ack | input | 1 | Receiver acknowledge |

## Verification
The bench builds the block with its default width of 32 bits. This lets it push all-zero, all-one and alternating-bit words through the full bus, next to random words, so a stuck or swapped data bit shows up at delivery.

A directed phase holds the receiver stalled and keeps its acknowledge high for long stretches. This exercises the blocked-sender case and the rule that no request may rise while the acknowledge is still high. A random phase then runs sender and receiver with independent random delays on every handshake edge, to cover the many interleavings of the two protocols.

// File: rtl/wordbuf_4ph_pkg.sv
package wordbuf_4ph_pkg;

    localparam int unsigned DEF_DATA_W = 32;

    typedef enum logic [0:0] {
        IN_IDLE = 1'b0,
        IN_HELD = 1'b1
    } in_state_t;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_OFFER = 2'd1,
        OUT_DRAIN = 2'd2
    } out_state_t;

    // Output side may open a transaction only with a word in hand,
    // the input side closed, and the receiver idle.
    function automatic logic offer_allowed(input logic full,
                                           input logic in_ack,
                                           input logic rx_ack);
        return full && !in_ack && !rx_ack;
    endfunction

endpackage

// File: rtl/wordbuf_4ph_inport.sv
module wordbuf_4ph_inport
    import wordbuf_4ph_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src_req,
    input  logic slot_full,
    output logic src_ack,
    output logic load
);

    in_state_t state_q;

    assign load    = (state_q == IN_IDLE) && src_req && !slot_full;
    assign src_ack = (state_q == IN_HELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IN_IDLE;
        end else begin
            unique case (state_q)
                IN_IDLE: if (load)     state_q <= IN_HELD;
                IN_HELD: if (!src_req) state_q <= IN_IDLE;
                default:               state_q <= IN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wordbuf_4ph_slot.sv
module wordbuf_4ph_slot #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         release_word,
    output logic         full,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else begin
            if (load) begin
                full <= 1'b1;
                word <= din;
            end else if (release_word) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wordbuf_4ph_outport.sv
module wordbuf_4ph_outport
    import wordbuf_4ph_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic slot_full,
    input  logic in_ack,
    input  logic dst_ack,
    output logic dst_req,
    output logic release_word
);

    out_state_t state_q;

    assign dst_req      = (state_q == OUT_OFFER);
    assign release_word = (state_q == OUT_OFFER) && dst_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_IDLE;
        end else begin
            unique case (state_q)
                OUT_IDLE:
                    if (offer_allowed(slot_full, in_ack, dst_ack)) state_q <= OUT_OFFER;
                OUT_OFFER:
                    if (dst_ack) state_q <= OUT_DRAIN;
                OUT_DRAIN:
                    if (!dst_ack) state_q <= OUT_IDLE;
                default:
                    state_q <= OUT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wordbuf_4ph.sv
module wordbuf_4ph
    import wordbuf_4ph_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_req,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ack,
    output logic              dst_req,
    output logic [DATA_W-1:0] dst_data,
    input  logic              dst_ack
);

    logic load;
    logic release_word;
    logic slot_full;

    wordbuf_4ph_inport u_in (
        .clk      (clk),
        .rst      (rst),
        .src_req  (src_req),
        .slot_full(slot_full),
        .src_ack  (src_ack),
        .load     (load)
    );

    wordbuf_4ph_slot #(.W(DATA_W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .din         (src_data),
        .release_word(release_word),
        .full        (slot_full),
        .word        (dst_data)
    );

    wordbuf_4ph_outport u_out (
        .clk         (clk),
        .rst         (rst),
        .slot_full   (slot_full),
        .in_ack      (src_ack),
        .dst_ack     (dst_ack),
        .dst_req     (dst_req),
        .release_word(release_word)
    );

endmodule

// File: rtl/wordbuf_4ph_chk.sv
module wordbuf_4ph_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         src_req,
    input logic [W-1:0] src_data,
    input logic         src_ack,
    input logic         dst_req,
    input logic [W-1:0] dst_data,
    input logic         dst_ack
);

    logic         prev_sa, prev_da, pending;
    logic [W-1:0] prev_din, last_word;
    logic         in_rise, out_rise;

    assign in_rise  = src_ack && !prev_sa;
    assign out_rise = dst_ack && !prev_da;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sa   <= 1'b0;
            prev_da   <= 1'b0;
            pending   <= 1'b0;
            prev_din  <= '0;
            last_word <= '0;
        end else begin
            prev_sa  <= src_ack;
            prev_da  <= dst_ack;
            prev_din <= src_data;
            if (in_rise) begin
                pending   <= 1'b1;
                last_word <= prev_din;
            end else if (out_rise) begin
                pending <= 1'b0;
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!src_ack && !dst_req)); // R1
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (!src_ack && !src_req) |=> !src_ack); // R3
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src_ack && src_req) |=> src_ack); // R3
    AST_REQ_AFTER_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        (!dst_req && src_ack) |=> !dst_req); // R5
    AST_REQ_NOT_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
        (!dst_req && dst_ack) |=> !dst_req); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dst_req && !dst_ack) |=> dst_req); // R6
    AST_DATA_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_rise |-> (dst_data == last_word)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        in_rise |-> !pending); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_rise |-> pending); // R9

endmodule

bind wordbuf_4ph wordbuf_4ph_chk #(.W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_req (src_req),
    .src_data(src_data),
    .src_ack (src_ack),
    .dst_req (dst_req),
    .dst_data(dst_data),
    .dst_ack (dst_ack)
);

// File: tb/wordbuf_4ph_test.sv
`timescale 1ns/1ps
module wordbuf_4ph_test;

    localparam int unsigned W = 32;
    localparam int unsigned NWORDS = 200;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         src_req = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_ack;
    logic         dst_req;
    logic [W-1:0] dst_data;
    logic         dst_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int in_rises = 0, out_rises = 0;
    logic         mon_sa = 1'b0, mon_da = 1'b0, monitor_on = 1'b0;
    logic [W-1:0] expq[$];

    always #2 clk = ~clk;

    wordbuf_4ph #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst),
        .src_req(src_req), .src_data(src_data), .src_ack(src_ack),
        .dst_req(dst_req), .dst_data(dst_data), .dst_ack(dst_ack)
    );

    function automatic logic [W-1:0] pattern(input int i);
        case (i % 8)
            0: return '0;
            1: return '1;
            2: return {(W/2){2'b10}};
            3: return {(W/2){2'b01}};
            default: return W'($urandom);
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts acknowledge rises on both sides; they must alternate (R8, R9).
    always @(negedge clk) begin
        if (monitor_on) begin
            if (src_ack && !mon_sa) begin
                in_rises++;
                check("R8", W'(in_rises - out_rises), W'(1));
            end
            if (dst_ack && !mon_da) begin
                out_rises++;
                check("R9", W'(in_rises - out_rises), W'(0));
            end
        end
        mon_sa = src_ack;
        mon_da = dst_ack;
    end

    task automatic sender();
        for (int i = 0; i < NWORDS; i++) begin
            cyc($urandom_range(0, 4));
            src_data = pattern(i);
            expq.push_back(src_data);
            src_req = 1'b1;
            while (!src_ack) cyc(1);
            cyc($urandom_range(0, 3));
            src_req = 1'b0;
            src_data = W'($urandom);
            while (src_ack) cyc(1);
        end
    endtask

    task automatic receiver();
        for (int i = 0; i < NWORDS; i++) begin
            while (!dst_req) cyc(1);
            cyc($urandom_range(0, 4));
            check("R7", dst_data, expq.pop_front());
            dst_ack = 1'b1;
            while (dst_req) cyc(1);
            cyc($urandom_range(0, 4));
            dst_ack = 1'b0;
        end
    endtask

    initial begin
        logic [W-1:0] wa, wb;
        void'($urandom(32'h5EED_0042));
        wa = 32'hA5A5_0F0F;
        wb = 32'h1234_FEDC;
        cyc(3);
        check("R1", W'({src_ack, dst_req}), W'(0));
        rst = 1'b0;
        cyc(1);

        // First word: accept timing and output request timing
        src_data = wa; src_req = 1'b1;
        cyc(1);
        check("R2", W'(src_ack), W'(1));
        src_req = 1'b0;
        cyc(1);
        check("R3", W'(src_ack), W'(0));
        check("R5", W'(dst_req), W'(0));
        cyc(1);
        check("R5", W'(dst_req), W'(1));
        check("R7", dst_data, wa);

        // Buffer full: second request must wait
        src_data = wb; src_req = 1'b1;
        cyc(5);
        check("R4", W'(src_ack), W'(0));
        check("R4", dst_data, wa);
        check("R6", W'(dst_req), W'(1));
        dst_ack = 1'b1;
        cyc(1);
        check("R6", W'(dst_req), W'(0));
        cyc(1);
        check("R4", W'(src_ack), W'(1));
        src_req = 1'b0;
        cyc(5);
        check("R6", W'(dst_req), W'(0));
        dst_ack = 1'b0;
        cyc(1);
        check("R6", W'(dst_req), W'(0));
        cyc(1);
        check("R6", W'(dst_req), W'(1));
        check("R7", dst_data, wb);
        dst_ack = 1'b1;
        cyc(1);
        dst_ack = 1'b0;
        cyc(2);

        // Random phase
        mon_sa = src_ack; mon_da = dst_ack;
        monitor_on = 1'b1;
        fork
            sender();
            receiver();
        join
        cyc(3);
        check("R9", W'(in_rises), W'(NWORDS));
        check("R8", W'(out_rises), W'(NWORDS));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule